// File: doc/BRIEF.md
# Type B frame serializer

This block turns a payload whose check bytes are already appended into the serial line stream of a proximity-card Type B frame. A single `start_i` pulse latches the framing side and the payload length. The block then emits one logical line bit every `CYC_PER_BIT` clock cycles. It pulls each payload byte through a ready/valid handshake at the moment that byte's character begins.

Tag-side framing puts a run of ones in front of the start-of-frame pattern, so that the far end can train its phase reference. It also closes the frame with a short high tail. Reader-side framing has no leading run. In reader mode the line is inverted, and the frame is padded with logical ones so that its total bit count is a whole number of 8-bit groups. Modulation, carrier control and check-byte generation are not part of this block. A one-cycle done pulse marks the end of the final bit.

Top module: `typeb_frame_ser`

## Requirements
- R1: Out of reset and between frames, `busy_o`, `line_o`, `data_ready_o` and `done_o` are all low.
- R2: In tag mode (`tag_mode_i`=1) the frame opens with 20 bits of logical one. These are followed by the start pattern: 10 bits of zero, then 2 bits of one.
- R3: In reader mode (`tag_mode_i`=0) the start pattern comes first, and every emitted bit appears on `line_o` inverted (`line_o` = NOT logical bit). In tag mode `line_o` equals the logical bit.
- R4: Each payload byte is a 10-bit character: one zero start bit, the 8 data bits least-significant first, and one stop bit of one.
- R5: The end pattern is 10 bits of zero. In tag mode 2 bits of one follow it, so a tag frame of N bytes is 44+10N bits long.
- R6: In reader mode, logical-one pad bits follow the end pattern until the total bit count is a multiple of 8, with 0 to 7 pad bits.
- R7: A byte count of zero gives the start pattern followed directly by the end pattern, and no handshake occurs.
- R8: Every bit lasts `CYC_PER_BIT` cycles. The one exception is a character's start bit when no byte has yet been taken: that bit lasts until the byte arrives, and a byte accepted in cycle c of the bit (counted from 0) makes the bit last max(`CYC_PER_BIT`, c+1) cycles.
- R9: `data_ready_o` is high only during a character's start bit, from its first cycle up to and including the cycle in which the byte is accepted.
- R10: `done_o` is high for exactly the final clock cycle of the last bit, and `busy_o` is low in the following cycle.
- R11: While `busy_o` is high, `start_i`, `tag_mode_i` and `byte_count_i` have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a frame when idle |
| tag_mode_i | input | 1 | 1 = tag-side framing, 0 = reader-side framing; latched at start |
| byte_count_i | input | LEN_W | Payload length in bytes; latched at start |
| data_i | input | 8 | Payload byte |
| data_valid_i | input | 1 | Payload byte valid |
| data_ready_o | output | 1 | Serializer wants the next byte |
| line_o | output | 1 | Serial line bit |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Last cycle of the last bit |

## Verification
Two events can land in the same cycle: the byte handshake and the end of a start bit's nominal period. If they coincide, the handshake must release the bit timer in that same cycle, with no extra cycle added and no cycle lost. The bench provokes this by holding `data_valid_i` low and raising it exactly in the final cycle of the first start bit, as well as one cycle earlier and several cycles later. It judges the result by the measured start-bit length, by the `data_ready_o` window, and by the data bits that follow.

// File: rtl/typeb_ser_pkg.sv
package typeb_ser_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_SOF_LO,
    PH_SOF_HI,
    PH_CHAR,
    PH_EOF_LO,
    PH_EOF_HI,
    PH_PAD
  } phase_e;

  localparam int CHAR_BITS = 10;
endpackage

// File: rtl/typeb_bit_timer.sv
module typeb_bit_timer #(
  parameter int CYC_PER_BIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hold_i,
  output logic bit_end_o
);
  localparam int CW = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_BIT - 1);

  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (!run_i) begin
      cyc_q <= '0;
    end else if (cyc_q == LAST) begin
      if (!hold_i) cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign bit_end_o = run_i && (cyc_q == LAST) && !hold_i;
endmodule

// File: rtl/typeb_char_shift.sv
module typeb_char_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       shift_i,
  output logic       bit_o
);
  // holds stop bit above the data bits; LSB is the bit on air
  logic [8:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
    end else if (load_i) begin
      sh_q <= {1'b1, byte_i};
    end else if (shift_i) begin
      sh_q <= {1'b1, sh_q[8:1]};
    end
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/typeb_frame_seq.sv
module typeb_frame_seq
  import typeb_ser_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int SYNC_BITS   = 20,
  parameter int SOF_LO_BITS = 10,
  parameter int SOF_HI_BITS = 2,
  parameter int EOF_LO_BITS = 10,
  parameter int EOF_HI_BITS = 2,
  parameter int GROUP_BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tag_mode_i,
  input  logic [LEN_W-1:0] byte_count_i,
  input  logic             bit_end_i,
  input  logic             fire_i,
  input  logic             char_bit_i,
  output logic             busy_o,
  output logic             tag_o,
  output logic             need_byte_o,
  output logic             shift_o,
  output logic             done_o,
  output logic             frame_bit_o
);
  localparam int CNT_W = $clog2(SYNC_BITS + SOF_LO_BITS + EOF_LO_BITS + CHAR_BITS + 1);
  localparam int GW    = (GROUP_BITS > 1) ? $clog2(GROUP_BITS) : 1;
  localparam logic [GW-1:0] GRP_LAST = GW'(GROUP_BITS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] idx_q, last_idx;
  logic [LEN_W-1:0] rem_q;
  logic [GW-1:0]    grp_q;
  logic             tag_q, have_q, adv, grp_full;

  always_comb begin
    case (phase_q)
      PH_SYNC:   last_idx = CNT_W'(SYNC_BITS - 1);
      PH_SOF_LO: last_idx = CNT_W'(SOF_LO_BITS - 1);
      PH_SOF_HI: last_idx = CNT_W'(SOF_HI_BITS - 1);
      PH_CHAR:   last_idx = CNT_W'(CHAR_BITS - 1);
      PH_EOF_LO: last_idx = CNT_W'(EOF_LO_BITS - 1);
      PH_EOF_HI: last_idx = CNT_W'(EOF_HI_BITS - 1);
      default:   last_idx = '0;
    endcase
  end

  assign grp_full = (grp_q == GRP_LAST);
  assign adv = bit_end_i && ((phase_q == PH_PAD) ? grp_full : (idx_q == last_idx));

  always_comb begin
    case (phase_q)
      PH_SYNC:   phase_d = PH_SOF_LO;
      PH_SOF_LO: phase_d = PH_SOF_HI;
      PH_SOF_HI: phase_d = (rem_q == '0) ? PH_EOF_LO : PH_CHAR;
      PH_CHAR:   phase_d = (rem_q == LEN_W'(1)) ? PH_EOF_LO : PH_CHAR;
      PH_EOF_LO: phase_d = tag_q ? PH_EOF_HI : (grp_full ? PH_IDLE : PH_PAD);
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      grp_q   <= '0;
      tag_q   <= 1'b0;
      have_q  <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (start_i) begin
        phase_q <= tag_mode_i ? PH_SYNC : PH_SOF_LO;
        tag_q   <= tag_mode_i;
        rem_q   <= byte_count_i;
        idx_q   <= '0;
        grp_q   <= '0;
        have_q  <= 1'b0;
      end
    end else begin
      if (fire_i) have_q <= 1'b1;
      if (bit_end_i) begin
        grp_q <= grp_q + 1'b1;
        if (adv) begin
          idx_q   <= '0;
          phase_q <= phase_d;
          if (phase_q == PH_CHAR) begin
            rem_q  <= rem_q - 1'b1;
            have_q <= 1'b0;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (phase_q)
      PH_SYNC, PH_SOF_HI, PH_EOF_HI, PH_PAD: frame_bit_o = 1'b1;
      PH_CHAR: frame_bit_o = (idx_q == '0) ? 1'b0 : char_bit_i;
      default: frame_bit_o = 1'b0;
    endcase
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign tag_o       = tag_q;
  assign need_byte_o = (phase_q == PH_CHAR) && (idx_q == '0) && !have_q;
  assign shift_o     = bit_end_i && (phase_q == PH_CHAR) && (idx_q != '0);
  assign done_o      = adv && (phase_d == PH_IDLE);
endmodule

// File: rtl/typeb_frame_ser.sv
module typeb_frame_ser #(
  parameter int CYC_PER_BIT = 4,
  parameter int LEN_W       = 6,
  parameter int SYNC_BITS   = 20,
  parameter int SOF_LO_BITS = 10,
  parameter int SOF_HI_BITS = 2,
  parameter int EOF_LO_BITS = 10,
  parameter int EOF_HI_BITS = 2,
  parameter int GROUP_BITS  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tag_mode_i,
  input  logic [LEN_W-1:0] byte_count_i,
  input  logic [7:0]       data_i,
  input  logic             data_valid_i,
  output logic             data_ready_o,
  output logic             line_o,
  output logic             busy_o,
  output logic             done_o
);
  logic bit_end, fire, need_byte, hold, shift, char_bit, frame_bit, tag_q, busy;

  assign fire = need_byte && data_valid_i;
  assign hold = need_byte && !data_valid_i;

  typeb_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .hold_i    (hold),
    .bit_end_o (bit_end)
  );

  typeb_char_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (fire),
    .byte_i  (data_i),
    .shift_i (shift),
    .bit_o   (char_bit)
  );

  typeb_frame_seq #(
    .LEN_W       (LEN_W),
    .SYNC_BITS   (SYNC_BITS),
    .SOF_LO_BITS (SOF_LO_BITS),
    .SOF_HI_BITS (SOF_HI_BITS),
    .EOF_LO_BITS (EOF_LO_BITS),
    .EOF_HI_BITS (EOF_HI_BITS),
    .GROUP_BITS  (GROUP_BITS)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .tag_mode_i   (tag_mode_i),
    .byte_count_i (byte_count_i),
    .bit_end_i    (bit_end),
    .fire_i       (fire),
    .char_bit_i   (char_bit),
    .busy_o       (busy),
    .tag_o        (tag_q),
    .need_byte_o  (need_byte),
    .shift_o      (shift),
    .done_o       (done_o),
    .frame_bit_o  (frame_bit)
  );

  // reader side drives an inverted line
  assign line_o       = busy && (tag_q ? frame_bit : !frame_bit);
  assign busy_o       = busy;
  assign data_ready_o = need_byte;
endmodule

// File: rtl/typeb_frame_ser_chk.sv
module typeb_frame_ser_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic data_ready_o,
  input logic line_o,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !line_o && !data_ready_o && !done_o); // R1

  AST_READY_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o |-> busy_o && !done_o); // R9

  AST_DONE_ENDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o); // R10

  AST_START_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o); // R11
endmodule

bind typeb_frame_ser typeb_frame_ser_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .data_ready_o (data_ready_o),
  .line_o       (line_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/typeb_frame_ser_tb_top.sv
module typeb_frame_ser_tb_top;
  localparam int CYC   = 4;
  localparam int LEN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, tag_mode_i = 1'b0, data_valid_i = 1'b0;
  logic [LEN_W-1:0] byte_count_i = '0;
  logic [7:0] data_i, seed_q = 8'h00;
  logic data_ready_o, line_o, busy_o, done_o;
  logic clr_k = 1'b0;
  int k = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  typeb_frame_ser #(.CYC_PER_BIT(CYC), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .tag_mode_i(tag_mode_i),
    .byte_count_i(byte_count_i), .data_i(data_i), .data_valid_i(data_valid_i),
    .data_ready_o(data_ready_o), .line_o(line_o), .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [7:0] pay(logic [7:0] s, int c);
    return 8'(int'(s) * 37 + c * 91 + 5);
  endfunction

  function automatic int frame_len(bit tag, int n);
    return tag ? 44 + 10 * n : ((22 + 10 * n + 7) / 8) * 8;
  endfunction

  function automatic logic exp_bit(bit tag, int n, logic [7:0] s, int i);
    int p = i;
    if (tag) begin
      if (p < 20) return 1'b1;
      p -= 20;
    end
    if (p < 10) return 1'b0;
    if (p < 12) return 1'b1;
    p -= 12;
    if (p < 10 * n) begin
      if (p % 10 == 0) return 1'b0;
      if (p % 10 == 9) return 1'b1;
      return pay(s, p / 10)[p % 10 - 1];
    end
    p -= 10 * n;
    if (p < 10) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string region(bit tag, int n, int i);
    int p = i;
    if (tag) begin
      if (p < 20) return "R2";
      p -= 20;
    end
    if (p < 12) return tag ? "R2" : "R3";
    p -= 12;
    if (p < 10 * n) return "R4";
    p -= 10 * n;
    if (p < 10) return (n == 0) ? "R7" : "R5";
    return tag ? "R5" : "R6";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (clr_k) k <= 0;
    else if (data_ready_o && data_valid_i) k <= k + 1;
  end
  assign data_i = pay(seed_q, k);

  task automatic run_frame(bit tag, int n, logic [7:0] s, int stall, bit disturb);
    int len, sb, lmis, dmis, rmis, first_i, act_l, exp_l;
    len = frame_len(tag, n);
    sb = (tag ? 20 : 0) + 12;
    lmis = 0; dmis = 0; rmis = 0; first_i = -1; act_l = 0; exp_l = 0;
    @(negedge clk);
    clr_k = 1'b1; seed_q = s; tag_mode_i = tag; byte_count_i = LEN_W'(n);
    start_i = 1'b1; data_valid_i = (stall == 0);
    @(negedge clk);
    clr_k = 1'b0; start_i = 1'b0;
    if (stall > 0) fork
      begin
        repeat (sb * CYC + stall) @(negedge clk);
        data_valid_i = 1'b1;
      end
    join_none
    if (disturb) fork
      begin
        repeat (25) @(negedge clk);
        start_i = 1'b1; tag_mode_i = ~tag; byte_count_i = LEN_W'(n + 3);
        @(negedge clk);
        start_i = 1'b0;
      end
    join_none
    for (int i = 0; i < len; i++) begin
      int d;
      bit is_start;
      logic el;
      d = (n > 0 && i == sb && stall + 1 > CYC) ? stall + 1 : CYC;
      is_start = (i >= sb) && (i < sb + 10 * n) && ((i - sb) % 10 == 0);
      el = tag ? exp_bit(tag, n, s, i) : ~exp_bit(tag, n, s, i);
      for (int j = 0; j < d; j++) begin
        if (j > 0) @(negedge clk);
        if (line_o !== el) begin
          lmis++;
          if (first_i < 0) begin first_i = i; act_l = int'(line_o); exp_l = int'(el); end
        end
        if (done_o !== (i == len - 1 && j == d - 1)) dmis++;
        if (data_ready_o !== (is_start && j <= ((i == sb) ? stall : 0))) rmis++;
        if (busy_o !== 1'b1) dmis++;
      end
      if (i < len - 1) @(negedge clk);
    end
    check(lmis == 0, (first_i < 0) ? "R4" : region(tag, n, first_i), act_l, exp_l);
    check(dmis == 0, (disturb ? "R11" : "R10"), dmis, 0);
    check(rmis == 0, (stall > 0 ? "R8" : "R9"), rmis, 0);
    @(negedge clk);
    check(!busy_o && !line_o && !done_o && !data_ready_o, "R10", int'(busy_o), 0);
    check(k == n, "R7", k, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !line_o && !data_ready_o && !done_o, "R1", int'(busy_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !line_o && !data_ready_o && !done_o, "R1", int'(line_o), 0);
    // sweep both modes over short payloads (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 9; n++)
        for (int sd = 0; sd < 2; sd++)
          run_frame(m[0], n, 8'(n * 13 + sd * 101 + 1), 0, 1'b0);
    run_frame(1'b1, 63, 8'h5a, 0, 1'b0);
    run_frame(1'b0, 63, 8'ha7, 0, 1'b0);
    // late byte: before, at and after the end of the start bit (R8 R9)
    for (int m = 0; m < 2; m++)
      for (int st = CYC - 2; st <= CYC + 3; st++)
        run_frame(m[0], 2, 8'(st * 7 + 3), st, 1'b0);
    // start/mode/count changes mid-frame are ignored (R11)
    run_frame(1'b1, 3, 8'h33, 0, 1'b1);
    run_frame(1'b0, 3, 8'h44, 0, 1'b1);
    run_frame(1'b0, 0, 8'h00, 0, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule